// File: doc/BRIEF.md
# Gate Driver Supply Fault Supervisor

This block is the protection controller that sits beside a synchronous buck gate driver. It receives digital flags from the analog comparators: the supply is above the power-on-reset level, the supply is above the start level, the supply is above the stop level (the start level less the hysteresis), and the switch node is above the pre-overvoltage level. From these flags it decides whether normal switching may proceed. It can also force the low-side switch on to drain an output that is already charged at power-up. Any fault is reported to the upstream controller by pulling a shared open-drain enable line low.

All asynchronous inputs pass through a multi-flop synchronizer. A five-state controller then acts on them. The five states are power-on reset, startup monitoring, running, undervoltage lockout and latched pre-overvoltage. The outputs are decoded from the state and from the sensed enable level. A pre-overvoltage event seen during startup is latched, and only a supply drop below the power-on-reset level clears it.

Top module: `drv_supply_supervisor`

## Requirements
- R1: During and just after reset the outputs are gate_enable=0, force_low_on=0 and en_pulldown=1.
- R2: A change on any comparator input reaches the state-decoded outputs on the (SYNC_STAGES+1)th rising edge after it is applied. A change on the sensed enable line reaches gate_enable on the SYNC_STAGES-th rising edge.
- R3: From any state, a supply below the power-on-reset level turns off both gate outputs and asserts en_pulldown. This condition takes priority over every other input.
- R4: When the supply is above power-on-reset but has not yet reached the start level, the block stays in startup monitoring. Both gate outputs are 0 and en_pulldown is 1.
- R5: In startup monitoring, a high switch-node overvoltage flag moves the block to the latched overvoltage state: force_low_on=1, gate_enable=0, en_pulldown=1. The flag wins when the start flag rises in the same cycle.
- R6: The latched overvoltage state ignores the start, stop, overvoltage and enable inputs. It is left only through a supply drop below power-on-reset, after which a normal startup is possible.
- R7: When the start flag is seen in startup monitoring, the block runs: en_pulldown=0, and gate_enable equals the sensed enable level (1 = high).
- R8: While running, a supply inside the hysteresis band (stop flag 1, start flag 0) keeps the block running.
- R9: While running, a stop flag of 0 enters undervoltage lockout: gate_enable=0, en_pulldown=1. The block stays there inside the hysteresis band and returns to running only when the start flag is 1.
- R10: The overvoltage flag has no effect while running or in undervoltage lockout.
- R11: While the block pulls the enable line low, the sensed enable level has no effect on its state changes. A low line does not block the move to running.
- R12: gate_enable and force_low_on are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_por_raw | input | 1 | Supply above power-on-reset level (async) |
| vcc_start_raw | input | 1 | Supply above start level (async) |
| vcc_stop_raw | input | 1 | Supply above stop level (async) |
| sw_ov_raw | input | 1 | Switch node above pre-overvoltage level (async) |
| en_line_raw | input | 1 | Sensed level of the shared enable line (async) |
| gate_enable | output | 1 | Normal switching allowed |
| force_low_on | output | 1 | Request to hold the low-side switch on |
| en_pulldown | output | 1 | Pull the enable line low (fault or not ready) |

## Verification
With the default two synchronizer stages, a comparator change applied before rising edge k shows on the state-decoded outputs after edge k+2. A change on the enable line reaches gate_enable after edge k+1. Because en_pulldown feeds back onto the enable wire, the rise of gate_enable at startup comes two edges after the release of en_pulldown. The bench drives inputs on falling edges and compares every output with a behavioural queue model on every falling edge, so each result is checked in the exact cycle it is due. Directed checks on the hysteresis, overvoltage and priority cases wait a stated number of edges, and R2 samples both sides of the latency boundary.

// File: rtl/dsup_pkg.sv
package dsup_pkg;

   typedef enum logic [2:0] {
      ST_POR     = 3'd0,
      ST_STARTUP = 3'd1,
      ST_RUN     = 3'd2,
      ST_UVLO    = 3'd3,
      ST_OVLATCH = 3'd4
   } sup_state_e;

   // Comparator and line flags after synchronization; por is bit 0
   typedef struct packed {
      logic en;
      logic ov;
      logic stop;
      logic start;
      logic por;
   } sup_flags_t;

   localparam int unsigned SUP_FLAG_W = $bits(sup_flags_t);

endpackage

// File: rtl/dsup_sync.sv
module dsup_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("dsup_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("dsup_sync: WIDTH must be at least 1");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], d_async[b]};
            end
         end
         assign q_sync[b] = chain_q[LAST];
      end
   endgenerate

endmodule

// File: rtl/dsup_fsm.sv
module dsup_fsm
   import dsup_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  sup_flags_t flags,
   output sup_state_e state_q
);

   sup_state_e state_d;

   always_comb begin
      state_d = state_q;
      if (!flags.por) begin
         state_d = ST_POR;
      end else begin
         unique case (state_q)
            ST_POR:     state_d = ST_STARTUP;
            ST_STARTUP: begin
               if (flags.ov)         state_d = ST_OVLATCH;
               else if (flags.start) state_d = ST_RUN;
            end
            ST_RUN:     if (!flags.stop) state_d = ST_UVLO;
            ST_UVLO:    if (flags.start) state_d = ST_RUN;
            ST_OVLATCH: state_d = ST_OVLATCH;
            default:    state_d = ST_POR;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_POR;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/dsup_outdec.sv
module dsup_outdec
   import dsup_pkg::*;
(
   input  sup_state_e state,
   input  logic       en_sensed,
   output logic       gate_enable,
   output logic       force_low_on,
   output logic       en_pulldown
);

   always_comb begin
      gate_enable  = 1'b0;
      force_low_on = 1'b0;
      en_pulldown  = 1'b1;
      unique case (state)
         ST_RUN: begin
            en_pulldown = 1'b0;
            gate_enable = en_sensed;
         end
         ST_OVLATCH: force_low_on = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/drv_supply_supervisor.sv
module drv_supply_supervisor
   import dsup_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vcc_por_raw,
   input  logic vcc_start_raw,
   input  logic vcc_stop_raw,
   input  logic sw_ov_raw,
   input  logic en_line_raw,
   output logic gate_enable,
   output logic force_low_on,
   output logic en_pulldown
);

   sup_flags_t flags_a;
   sup_flags_t flags_s;
   sup_state_e state;

   assign flags_a = '{en: en_line_raw, ov: sw_ov_raw, stop: vcc_stop_raw,
                      start: vcc_start_raw, por: vcc_por_raw};

   dsup_sync #(
      .WIDTH  (SUP_FLAG_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (flags_a),
      .q_sync  (flags_s)
   );

   dsup_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags   (flags_s),
      .state_q (state)
   );

   dsup_outdec u_dec (
      .state        (state),
      .en_sensed    (flags_s.en),
      .gate_enable  (gate_enable),
      .force_low_on (force_low_on),
      .en_pulldown  (en_pulldown)
   );

endmodule

// File: rtl/dsup_checker.sv
module dsup_checker
   import dsup_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input sup_flags_t sync_f,
   input logic       gate_enable,
   input logic       force_low_on,
   input logic       en_pulldown
);

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_enable && force_low_on)); // R12

   AST_POR_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_f.por |=> (!gate_enable && !force_low_on && en_pulldown)); // R3

   AST_UV_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_f.por && !sync_f.stop && !sync_f.start) |=> !gate_enable); // R9

   AST_OV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (force_low_on && sync_f.por) |=> force_low_on); // R6

   AST_FORCE_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
      force_low_on |-> (en_pulldown && !gate_enable)); // R5

   AST_RUN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      gate_enable |-> !en_pulldown); // R7

endmodule

bind drv_supply_supervisor dsup_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sync_f       (flags_s),
   .gate_enable  (gate_enable),
   .force_low_on (force_low_on),
   .en_pulldown  (en_pulldown)
);

// File: tb/drv_supply_supervisor_tb.sv
module drv_supply_supervisor_tb;

   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic por_r = 1'b0, start_r = 1'b0, stop_r = 1'b0, ov_r = 1'b0;
   logic en_ctl = 1'b0;
   logic en_line;
   logic gate_enable, force_low_on, en_pulldown;

   int n_chk = 0;
   int n_fail = 0;
   string phase_req = "R1";

   always #4 clk = ~clk;

   // open-drain wire: controller drives high, block may pull low
   assign en_line = en_ctl && !en_pulldown;

   drv_supply_supervisor #(.SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .vcc_por_raw(por_r), .vcc_start_raw(start_r), .vcc_stop_raw(stop_r),
      .sw_ov_raw(ov_r), .en_line_raw(en_line),
      .gate_enable(gate_enable), .force_low_on(force_low_on),
      .en_pulldown(en_pulldown)
   );

   task automatic chk(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // states: 0 por, 1 startup, 2 run, 3 uvlo, 4 ov latched
   logic [4:0] m_q[$];
   int m_st = 0;
   bit seen[5][5];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q = {};
         for (int i = 0; i < SYNC; i++) m_q.push_back(5'b0);
         m_st = 0;
      end else begin
         logic [4:0] v;
         int nx;
         v = m_q.pop_front();
         // v = {en, ov, stop, start, por}
         if (!v[0])            nx = 0;
         else if (m_st == 0)   nx = 1;
         else if (m_st == 1)   nx = v[3] ? 4 : (v[1] ? 2 : 1);
         else if (m_st == 2)   nx = v[2] ? 2 : 3;
         else if (m_st == 3)   nx = v[1] ? 2 : 3;
         else                  nx = 4;
         if (nx != m_st) seen[m_st][nx] = 1'b1;
         m_st = nx;
         m_q.push_back({en_line, ov_r, stop_r, start_r, por_r});
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(phase_req, "model gate_enable", gate_enable, (m_st == 2) && m_q[0][4]);
         chk(phase_req, "model force_low_on", force_low_on, m_st == 4);
         chk(phase_req, "model en_pulldown", en_pulldown, m_st != 2);
         chk("R12", "overlap", gate_enable && force_low_on, 1'b0);
      end
   end

   // ---------------- stimulus helpers ----------------
   // level 0: below por, 1: por only, 2: hysteresis band, 3: above start
   task automatic set_lvl(int lvl);
      por_r   = (lvl >= 1);
      stop_r  = (lvl >= 2);
      start_r = (lvl >= 3);
   endtask

   task automatic wait_n(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic outs(string req, logic g, logic f, logic p);
      chk(req, "gate_enable", gate_enable, g);
      chk(req, "force_low_on", force_low_on, f);
      chk(req, "en_pulldown", en_pulldown, p);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      phase_req = "R1";
      outs("R1", 1'b0, 1'b0, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      outs("R1", 1'b0, 1'b0, 1'b1);

      // startup monitoring with controller enable high
      phase_req = "R4";
      en_ctl = 1'b1;
      set_lvl(1);
      wait_n(4);
      outs("R4", 1'b0, 1'b0, 1'b1);

      // latency boundary on comparator path
      phase_req = "R2";
      set_lvl(3);
      wait_n(2);
      chk("R2", "pulldown before due edge", en_pulldown, 1'b1);
      wait_n(1);
      chk("R2", "pulldown at due edge", en_pulldown, 1'b0);
      chk("R2", "gate before line synced", gate_enable, 1'b0);
      wait_n(2);
      phase_req = "R7";
      outs("R7", 1'b1, 1'b0, 1'b0);

      // enable line path latency
      phase_req = "R2";
      en_ctl = 1'b0;
      wait_n(1);
      chk("R2", "gate one edge after line low", gate_enable, 1'b1);
      wait_n(1);
      chk("R2", "gate two edges after line low", gate_enable, 1'b0);
      en_ctl = 1'b1;
      wait_n(3);
      chk("R7", "gate follows line high", gate_enable, 1'b1);

      // hysteresis band keeps running
      phase_req = "R8";
      set_lvl(2);
      wait_n(6);
      outs("R8", 1'b1, 1'b0, 1'b0);

      // overvoltage ignored while running
      phase_req = "R10";
      ov_r = 1'b1;
      wait_n(6);
      outs("R10", 1'b1, 1'b0, 1'b0);
      ov_r = 1'b0;

      // drop below stop: undervoltage lockout
      phase_req = "R9";
      set_lvl(1);
      wait_n(4);
      outs("R9", 1'b0, 1'b0, 1'b1);
      set_lvl(2);
      wait_n(6);
      outs("R9", 1'b0, 1'b0, 1'b1);
      phase_req = "R10";
      ov_r = 1'b1;
      wait_n(6);
      outs("R10", 1'b0, 1'b0, 1'b1);
      ov_r = 1'b0;
      wait_n(3);

      // enable line held low by controller does not block recovery
      phase_req = "R11";
      en_ctl = 1'b0;
      set_lvl(3);
      wait_n(4);
      outs("R11", 1'b0, 1'b0, 1'b0);
      en_ctl = 1'b1;
      wait_n(3);
      chk("R9", "returned to run", gate_enable, 1'b1);

      // run -> por
      phase_req = "R3";
      set_lvl(0);
      wait_n(4);
      outs("R3", 1'b0, 1'b0, 1'b1);

      // por -> startup -> run -> uvlo -> por
      set_lvl(3);
      wait_n(6);
      set_lvl(1);
      wait_n(4);
      set_lvl(0);
      wait_n(4);
      outs("R3", 1'b0, 1'b0, 1'b1);

      // startup -> por
      set_lvl(1);
      wait_n(4);
      set_lvl(0);
      wait_n(4);
      outs("R3", 1'b0, 1'b0, 1'b1);

      // overvoltage at startup latches
      phase_req = "R5";
      set_lvl(1);
      wait_n(4);
      ov_r = 1'b1;
      wait_n(4);
      outs("R5", 1'b0, 1'b1, 1'b1);

      // latch holds against every other input
      phase_req = "R6";
      ov_r = 1'b0;
      set_lvl(3);
      en_ctl = 1'b1;
      wait_n(6);
      outs("R6", 1'b0, 1'b1, 1'b1);
      set_lvl(2);
      wait_n(4);
      outs("R6", 1'b0, 1'b1, 1'b1);
      set_lvl(1);
      wait_n(4);
      outs("R6", 1'b0, 1'b1, 1'b1);
      set_lvl(0);
      wait_n(4);
      outs("R6", 1'b0, 1'b0, 1'b1);
      set_lvl(3);
      wait_n(8);
      outs("R6", 1'b1, 1'b0, 1'b0);

      // overvoltage and start together in startup: overvoltage wins
      phase_req = "R5";
      set_lvl(0);
      wait_n(4);
      set_lvl(1);
      wait_n(4);
      ov_r = 1'b1;
      set_lvl(3);
      wait_n(4);
      outs("R5", 1'b0, 1'b1, 1'b1);
      ov_r = 1'b0;
      set_lvl(0);
      wait_n(4);
      outs("R3", 1'b0, 1'b0, 1'b1);

      // every state change exercised
      chk("R4", "seen por->startup", seen[0][1], 1'b1);
      chk("R3", "seen startup->por", seen[1][0], 1'b1);
      chk("R5", "seen startup->ovlatch", seen[1][4], 1'b1);
      chk("R7", "seen startup->run", seen[1][2], 1'b1);
      chk("R3", "seen run->por", seen[2][0], 1'b1);
      chk("R9", "seen run->uvlo", seen[2][3], 1'b1);
      chk("R3", "seen uvlo->por", seen[3][0], 1'b1);
      chk("R9", "seen uvlo->run", seen[3][2], 1'b1);
      chk("R6", "seen ovlatch->por", seen[4][0], 1'b1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule